// File: doc/BRIEF.md
# Multi-Region Instruction Fetch Sequencer

This block is the fetch front end of a small 32-bit core. Each program-counter value is a long (32-bit word) index. The block sends it to one of three places. Low indices go to a local register RAM. The next range goes to a local lookup RAM. Everything above that goes to a shared hub memory. Hub words come from a one-line prefetch cache. The cache is refilled through a round-robin access slot, which is visible to the block only as a grant pulse. The block hands the core at most one instruction word per cycle, with a valid flag and the index it was fetched from. Decode and execute sit downstream.

The core always starts in hub execution, at a byte address carried by the start request. It stays in hub execution for sequential fetch until a taken jump sends it elsewhere. A jump is routed by address range. A jump into hub space throws away the cached line, so fetch waits for the next grant and a refill. A jump into either local RAM streams again one cycle later. A stop halts fetch and empties the cache. A later start resumes at the newly supplied address.

Top module: `instr_fetch_seq`

## Requirements
- R1: Outside hub mode, an index in 0..511 reads the register RAM port with address equal to the index, and an index in 512..1023 reads the lookup RAM port with address equal to the index minus 512. The RAM word, returned one cycle after the read strobe, is presented on `instr_o` while `instr_valid_o` is high.
- R2: An index of 1024 or more is served from hub memory. `hub_addr_o` gives the byte address of the 4-long line base. The line comes back on `hub_line_i` in the cycle after the request, with long k of the line in bits 32k+31..32k.
- R3: A start sampled on a clock edge puts the block in hub mode at index `start_addr_i >> 2`, whatever that value is, including values below 1024. Sequential fetch stays in hub mode until a jump.
- R4: Bits 1..0 of start and jump byte addresses are ignored, so every fetch is long-aligned.
- R5: After a jump into local RAM, `instr_valid_o` is low in the cycle after the jump edge and high in the cycle after that. Local words then arrive every cycle with no hub request.
- R6: `hub_req_o` is raised only in a cycle where `hub_grant_i` is high. The first word of the refilled line appears three cycles after the request cycle. The remaining words of the line follow on consecutive cycles with no further request.
- R7: A taken jump into hub space invalidates the cache, so a refill occurs even when the target line was already held.
- R8: A stop makes `instr_valid_o` low from the next cycle on. While stopped there are no reads and no hub requests, and jumps are ignored. A start after a stop refills from the hub even for the previously cached line.
- R9: Consecutive valid words carry indices that differ by one. Sequential fetch crosses the 511/512 and 1023/1024 boundaries by switching source, and the index wraps to 0 after 2^20-1.
- R10: A stop takes priority over a start in the same cycle, and a start takes priority over a jump in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request (begins hub execution) |
| start_addr_i | input | 22 | Start byte address |
| stop_i | input | 1 | Stop request |
| jump_i | input | 1 | Taken jump from the execute stage |
| jump_addr_i | input | 22 | Jump target byte address |
| hub_grant_i | input | 1 | Hub access slot belongs to this core this cycle |
| hub_req_o | output | 1 | Line refill request |
| hub_addr_o | output | 22 | Byte address of the requested line |
| hub_line_i | input | 128 | Refilled line, one cycle after the request |
| reg_rd_o | output | 1 | Register RAM read strobe |
| reg_addr_o | output | 9 | Register RAM address |
| reg_data_i | input | 32 | Register RAM data, one cycle after the strobe |
| lut_rd_o | output | 1 | Lookup RAM read strobe |
| lut_addr_o | output | 9 | Lookup RAM address |
| lut_data_i | input | 32 | Lookup RAM data, one cycle after the strobe |
| instr_o | output | 32 | Fetched instruction word |
| instr_pc_o | output | 20 | Long index of the fetched word |
| instr_valid_o | output | 1 | Instruction word valid |

## Verification
The bench builds the block with its defaults: a 20-bit long index, 4-long lines, and 512-entry register and lookup regions. It pairs these with a grant that rises one cycle in every eight. At this width, a start near the top of hub space reaches the index wrap within a few words. The small regions let single jumps land just below the 511/512 and 1023/1024 boundaries. The four-word line makes a line crossing, and its second refill, appear within a six-word window.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_LUT = 2'd1,
        SRC_HUB = 2'd2
    } fetch_src_e;

    typedef enum logic {
        RF_IDLE = 1'b0,
        RF_FILL = 1'b1
    } refill_state_e;

    localparam int unsigned WORD_W = 32;

endpackage

// File: rtl/ifs_region_decode.sv
module ifs_region_decode
    import ifs_pkg::*;
#(
    parameter int unsigned PC_W      = 20,
    parameter int unsigned REG_WORDS = 512,
    parameter int unsigned LUT_WORDS = 512
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            hub_mode_i,
    output fetch_src_e      src_o
);

    localparam logic [PC_W-1:0] REG_END = PC_W'(REG_WORDS);
    localparam logic [PC_W-1:0] LUT_END = PC_W'(REG_WORDS + LUT_WORDS);

    // Hub mode overrides the range map; otherwise the index picks the memory.
    always_comb begin
        if (hub_mode_i || (pc_i >= LUT_END)) begin
            src_o = SRC_HUB;
        end else if (pc_i < REG_END) begin
            src_o = SRC_REG;
        end else begin
            src_o = SRC_LUT;
        end
    end

endmodule

// File: rtl/ifs_line_cache.sv
module ifs_line_cache
    import ifs_pkg::*;
#(
    parameter int unsigned PC_W       = 20,
    parameter int unsigned LINE_WORDS = 4
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         inv_i,
    input  logic                         fill_i,
    input  logic [PC_W-$clog2(LINE_WORDS)-1:0] fill_tag_i,
    input  logic [LINE_WORDS*WORD_W-1:0] fill_line_i,
    input  logic [PC_W-1:0]              pc_i,
    output logic                         hit_o,
    output logic [WORD_W-1:0]            word_o
);

    localparam int unsigned OFS_W = $clog2(LINE_WORDS);
    localparam int unsigned TAG_W = PC_W - OFS_W;

    typedef struct packed {
        logic                               vld;
        logic [TAG_W-1:0]                   tag;
        logic [LINE_WORDS-1:0][WORD_W-1:0]  line;
    } cache_st_t;

    cache_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fill_i) begin
            st_d.vld  = 1'b1;
            st_d.tag  = fill_tag_i;
            st_d.line = fill_line_i;
        end
        if (inv_i) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o  = st_q.vld && (st_q.tag == pc_i[PC_W-1:OFS_W]);
    assign word_o = st_q.line[pc_i[OFS_W-1:0]];

    AST_INV_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inv_i |=> !hit_o); // R7

endmodule

// File: rtl/ifs_hub_refill.sv
module ifs_hub_refill
    import ifs_pkg::*;
#(
    parameter int unsigned PC_W       = 20,
    parameter int unsigned LINE_WORDS = 4
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               need_i,
    input  logic                               grant_i,
    input  logic                               flush_i,
    input  logic [PC_W-$clog2(LINE_WORDS)-1:0] tag_i,
    output logic                               hub_req_o,
    output logic [PC_W+1:0]                    hub_addr_o,
    input  logic [LINE_WORDS*WORD_W-1:0]       hub_line_i,
    output logic                               fill_o,
    output logic [PC_W-$clog2(LINE_WORDS)-1:0] fill_tag_o,
    output logic [LINE_WORDS*WORD_W-1:0]       fill_line_o
);

    localparam int unsigned OFS_W = $clog2(LINE_WORDS);
    localparam int unsigned TAG_W = PC_W - OFS_W;

    typedef struct packed {
        refill_state_e    st;
        logic [TAG_W-1:0] tag;
    } rf_st_t;

    rf_st_t st_d, st_q;

    // A request leaves only in a granted cycle while no fill is pending.
    assign hub_req_o  = (st_q.st == RF_IDLE) && need_i && grant_i;
    assign hub_addr_o = {tag_i, {OFS_W{1'b0}}, 2'b00};

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            RF_IDLE: begin
                if (hub_req_o) begin
                    st_d.st  = RF_FILL;
                    st_d.tag = tag_i;
                end
            end
            RF_FILL: begin
                st_d.st = RF_IDLE;
            end
            default: st_d.st = RF_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{st: RF_IDLE, tag: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // A line landing after a redirect is stale and is dropped.
    assign fill_o      = (st_q.st == RF_FILL) && !flush_i;
    assign fill_tag_o  = st_q.tag;
    assign fill_line_o = hub_line_i;

    AST_FILL_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_o |-> $past(hub_req_o)); // R6
    AST_NO_BACK_TO_BACK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hub_req_o |=> !hub_req_o); // R6

endmodule

// File: rtl/instr_fetch_seq.sv
module instr_fetch_seq
    import ifs_pkg::*;
#(
    parameter int unsigned PC_W       = 20,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned REG_WORDS  = 512,
    parameter int unsigned LUT_WORDS  = 512
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    input  logic [PC_W+1:0]              start_addr_i,
    input  logic                         stop_i,
    input  logic                         jump_i,
    input  logic [PC_W+1:0]              jump_addr_i,
    input  logic                         hub_grant_i,
    output logic                         hub_req_o,
    output logic [PC_W+1:0]              hub_addr_o,
    input  logic [LINE_WORDS*WORD_W-1:0] hub_line_i,
    output logic                         reg_rd_o,
    output logic [$clog2(REG_WORDS)-1:0] reg_addr_o,
    input  logic [WORD_W-1:0]            reg_data_i,
    output logic                         lut_rd_o,
    output logic [$clog2(LUT_WORDS)-1:0] lut_addr_o,
    input  logic [WORD_W-1:0]            lut_data_i,
    output logic [WORD_W-1:0]            instr_o,
    output logic [PC_W-1:0]              instr_pc_o,
    output logic                         instr_valid_o
);

    localparam int unsigned REG_AW = $clog2(REG_WORDS);
    localparam int unsigned LUT_AW = $clog2(LUT_WORDS);
    localparam int unsigned OFS_W  = $clog2(LINE_WORDS);
    localparam int unsigned TAG_W  = PC_W - OFS_W;
    localparam int unsigned LINE_W = LINE_WORDS * WORD_W;

    typedef struct packed {
        logic              run;
        logic              hubx;
        logic [PC_W-1:0]   pc;
        logic              vld;
        fetch_src_e        src;
        logic [PC_W-1:0]   opc;
        logic [WORD_W-1:0] hword;
    } seq_st_t;

    seq_st_t st_d, st_q;

    fetch_src_e        cur_src, jmp_src;
    logic              hit;
    logic [WORD_W-1:0] hit_word;
    logic              need, flush, fill, redirect, jump_take, issue;
    logic [TAG_W-1:0]  fill_tag;
    logic [LINE_W-1:0] fill_line;
    logic [PC_W-1:0]   start_pc, jump_pc, lut_ofs;
    logic              unused_lowbits;

    // Long alignment: the byte-lane bits of a target are dropped.
    assign start_pc       = start_addr_i[PC_W+1:2];
    assign jump_pc        = jump_addr_i[PC_W+1:2];
    assign unused_lowbits = ^{start_addr_i[1:0], jump_addr_i[1:0]};

    ifs_region_decode #(
        .PC_W(PC_W), .REG_WORDS(REG_WORDS), .LUT_WORDS(LUT_WORDS)
    ) u_cur_dec (
        .pc_i(st_q.pc), .hub_mode_i(st_q.hubx), .src_o(cur_src)
    );

    ifs_region_decode #(
        .PC_W(PC_W), .REG_WORDS(REG_WORDS), .LUT_WORDS(LUT_WORDS)
    ) u_jmp_dec (
        .pc_i(jump_pc), .hub_mode_i(1'b0), .src_o(jmp_src)
    );

    ifs_line_cache #(
        .PC_W(PC_W), .LINE_WORDS(LINE_WORDS)
    ) u_cache (
        .clk_i(clk_i), .rst_ni(rst_ni), .inv_i(flush), .fill_i(fill),
        .fill_tag_i(fill_tag), .fill_line_i(fill_line), .pc_i(st_q.pc),
        .hit_o(hit), .word_o(hit_word)
    );

    ifs_hub_refill #(
        .PC_W(PC_W), .LINE_WORDS(LINE_WORDS)
    ) u_refill (
        .clk_i(clk_i), .rst_ni(rst_ni), .need_i(need), .grant_i(hub_grant_i),
        .flush_i(flush), .tag_i(st_q.pc[PC_W-1:OFS_W]),
        .hub_req_o(hub_req_o), .hub_addr_o(hub_addr_o), .hub_line_i(hub_line_i),
        .fill_o(fill), .fill_tag_o(fill_tag), .fill_line_o(fill_line)
    );

    // Priority: stop, then start, then a jump (only while running).
    assign jump_take = jump_i && st_q.run && !stop_i && !start_i;
    assign redirect  = stop_i || start_i || jump_take;
    assign flush     = stop_i || start_i || (jump_take && (jmp_src == SRC_HUB));
    assign issue     = st_q.run && !redirect && ((cur_src != SRC_HUB) || hit);
    assign need      = st_q.run && !redirect && (cur_src == SRC_HUB) && !hit;

    always_comb begin
        st_d     = st_q;
        st_d.vld = issue;
        if (issue) begin
            st_d.src   = cur_src;
            st_d.opc   = st_q.pc;
            st_d.hword = hit_word;
            st_d.pc    = st_q.pc + 1'b1;
        end
        if (jump_take) begin
            st_d.pc   = jump_pc;
            st_d.hubx = (jmp_src == SRC_HUB);
        end
        if (start_i) begin
            st_d.run  = 1'b1;
            st_d.hubx = 1'b1;
            st_d.pc   = start_pc;
        end
        if (stop_i) begin
            st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lut_ofs    = st_q.pc - PC_W'(REG_WORDS);
    assign reg_rd_o   = issue && (cur_src == SRC_REG);
    assign reg_addr_o = st_q.pc[REG_AW-1:0];
    assign lut_rd_o   = issue && (cur_src == SRC_LUT);
    assign lut_addr_o = lut_ofs[LUT_AW-1:0];

    always_comb begin
        unique case (st_q.src)
            SRC_REG: instr_o = reg_data_i;
            SRC_LUT: instr_o = lut_data_i;
            default: instr_o = st_q.hword;
        endcase
    end

    assign instr_pc_o    = st_q.opc;
    assign instr_valid_o = st_q.vld;

    AST_STOP_CLEARS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !instr_valid_o); // R8
    AST_JUMP_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        jump_i |=> !instr_valid_o); // R5
    AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        instr_valid_o && $past(instr_valid_o) |-> instr_pc_o == $past(instr_pc_o) + 1'b1); // R9
    AST_LOCAL_NO_HUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd_o || lut_rd_o) |-> !hub_req_o); // R1
    AST_START_IN_HUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !stop_i |=> !reg_rd_o && !lut_rd_o); // R3

endmodule

// File: tb/instr_fetch_seq_tb.sv
module instr_fetch_seq_tb;

    localparam int LW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0, stop_i = 1'b0, jump_i = 1'b0;
    logic [21:0]  start_addr_i = '0, jump_addr_i = '0;
    logic         hub_grant;
    logic         hub_req_o;
    logic [21:0]  hub_addr_o;
    logic [LW*32-1:0] hub_line;
    logic         reg_rd_o, lut_rd_o;
    logic [8:0]   reg_addr_o, lut_addr_o;
    logic [31:0]  reg_data, lut_data;
    logic [31:0]  instr_o;
    logic [19:0]  instr_pc_o;
    logic         instr_valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    instr_fetch_seq u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .start_i(start_i), .start_addr_i(start_addr_i),
        .stop_i(stop_i), .jump_i(jump_i), .jump_addr_i(jump_addr_i),
        .hub_grant_i(hub_grant), .hub_req_o(hub_req_o), .hub_addr_o(hub_addr_o),
        .hub_line_i(hub_line),
        .reg_rd_o(reg_rd_o), .reg_addr_o(reg_addr_o), .reg_data_i(reg_data),
        .lut_rd_o(lut_rd_o), .lut_addr_o(lut_addr_o), .lut_data_i(lut_data),
        .instr_o(instr_o), .instr_pc_o(instr_pc_o), .instr_valid_o(instr_valid_o)
    );

    // Environment models: grant one cycle in eight, synchronous RAMs, hub.
    logic [2:0]  gcnt = '0;
    logic [21:0] hub_addr_q = '0;
    logic [8:0]  reg_addr_q = '0, lut_addr_q = '0;

    always @(posedge clk) begin
        gcnt       <= gcnt + 3'd1;
        reg_addr_q <= reg_addr_o;
        lut_addr_q <= lut_addr_o;
        if (hub_req_o) hub_addr_q <= hub_addr_o;
    end

    assign hub_grant = (gcnt == 3'd7);
    assign reg_data  = {12'hA00, 11'b0, reg_addr_q};
    assign lut_data  = {12'hB00, 11'b0, lut_addr_q};

    always_comb begin
        for (int w = 0; w < LW; w++) begin
            hub_line[32*w +: 32] = {12'hC50, hub_addr_q[21:2] + 20'(w)};
        end
    end

    function automatic logic [31:0] exp_word(logic [19:0] p, bit hx);
        if (hx || p >= 20'd1024) return {12'hC50, p};
        else if (p < 20'd512)    return {12'hA00, 11'b0, p[8:0]};
        else                     return {12'hB00, 11'b0, p[8:0]};
    endfunction

    task automatic chk(bit ok, string rq, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_op(bit isjump, logic [21:0] a);
        if (isjump) begin jump_i = 1'b1; jump_addr_i = a; end
        else begin start_i = 1'b1; start_addr_i = a; end
        step();
        jump_i  = 1'b0;
        start_i = 1'b0;
    endtask

    task automatic collect(input int n, input logic [19:0] pc0, input bit hx, input string rq,
                           output int first_idx, output int req_before, output int lat,
                           output int mid_reqs, output int gaps);
        int got = 0;
        int idx = 0;
        int last_req = -100;
        int last_valid = -1;
        logic [19:0] ep = pc0;
        first_idx = -1; req_before = 0; lat = -1; mid_reqs = 0; gaps = 0;
        while (got < n && idx < 100) begin
            if (hub_req_o) begin
                chk(hub_grant, "R6", "request outside grant", hub_grant, 1);
                if (got == 0) begin
                    req_before++;
                    last_req = idx;
                end else if (!(instr_valid_o && got == n - 1)) begin
                    mid_reqs++;
                end
            end
            if (instr_valid_o) begin
                if (got == 0) begin
                    first_idx = idx;
                    lat = idx - last_req;
                end else if (idx != last_valid + 1) begin
                    gaps++;
                end
                chk(instr_pc_o == ep, rq, "word index", instr_pc_o, ep);
                chk(instr_o == exp_word(ep, hx), rq, "word data", instr_o, exp_word(ep, hx));
                last_valid = idx;
                ep = ep + 20'd1;
                got++;
            end
            idx++;
            if (got < n) step();
        end
        if (got < n) chk(1'b0, rq, "words before timeout", got, n);
    endtask

    task automatic quiet(int n, string rq);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (instr_valid_o || hub_req_o || reg_rd_o || lut_rd_o) bad++;
            step();
        end
        chk(bad == 0, rq, "activity while stopped", bad, 0);
    endtask

    typedef struct packed {
        logic        isjump;
        logic [21:0] addr;
        logic [7:0]  nwords;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 22'h002000, 8'd6},  // start, hub, crosses a line
        '{1'b1, 22'h000040, 8'd5},  // register RAM
        '{1'b1, 22'h0007F8, 8'd4},  // register to lookup boundary
        '{1'b1, 22'h000900, 8'd3},  // lookup RAM
        '{1'b0, 22'h000105, 8'd3},  // unaligned start below 1024
        '{1'b1, 22'h001FFC, 8'd3},  // hub line crossing
        '{1'b1, 22'h000FFC, 8'd3},  // lookup to hub boundary
        '{1'b0, 22'h3FFFFE, 8'd3}   // index wrap
    };
    string lbl [NV] = '{"R2 R3", "R1 R5", "R1 R9", "R1", "R3 R4", "R2 R7 R9", "R1 R9", "R3 R9"};

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int fi, rb, lt, mr, gp;
        repeat (4) @(posedge clk);
        #1;
        chk(!instr_valid_o && !hub_req_o && !reg_rd_o && !lut_rd_o, "R8", "reset idle",
            {instr_valid_o, hub_req_o, reg_rd_o, lut_rd_o}, 0);
        rst_n = 1'b1;
        quiet(10, "R8");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [19:0] p;
            bit hx;
            p  = VECS[v].addr[21:2];
            hx = VECS[v].isjump ? (p >= 20'd1024) : 1'b1;
            do_op(VECS[v].isjump, VECS[v].addr);
            collect(int'(VECS[v].nwords), p, hx, lbl[v], fi, rb, lt, mr, gp);
        end

        // R5: local stream, one-cycle latency, no stall
        do_op(1'b1, 22'h000100);
        collect(8, 20'd64, 1'b0, "R5", fi, rb, lt, mr, gp);
        chk(fi == 1, "R5", "first valid sample", fi, 1);
        chk(gp == 0, "R5", "stall gaps", gp, 0);
        chk(rb + mr == 0, "R5", "hub requests", rb + mr, 0);

        // R6: refill timing and line hits
        do_op(1'b0, 22'h004000);
        collect(4, 20'h01000, 1'b1, "R6", fi, rb, lt, mr, gp);
        chk(rb >= 1, "R6", "refill requested", rb, 1);
        chk(lt == 3, "R6", "request to first word", lt, 3);
        chk(gp == 0, "R6", "gaps within line", gp, 0);
        chk(mr == 0, "R6", "requests within line", mr, 0);
        chk(fi <= 11, "R6", "start latency bound", fi, 11);

        // R7: jump into the cached line still refills
        do_op(1'b0, 22'h004000);
        collect(2, 20'h01000, 1'b1, "R7", fi, rb, lt, mr, gp);
        do_op(1'b1, 22'h004008);
        collect(3, 20'h01002, 1'b1, "R7", fi, rb, lt, mr, gp);
        chk(rb >= 1, "R7", "refill after hub jump", rb, 1);

        // R8: stop, then jump while stopped
        do_op(1'b1, 22'h000200);
        collect(3, 20'd128, 1'b0, "R8", fi, rb, lt, mr, gp);
        stop_i = 1'b1;
        step();
        stop_i = 1'b0;
        quiet(12, "R8");
        do_op(1'b1, 22'h000040);
        quiet(10, "R8");

        // R10: stop beats start
        stop_i = 1'b1; start_i = 1'b1; start_addr_i = 22'h004010;
        step();
        stop_i = 1'b0; start_i = 1'b0;
        quiet(10, "R10");

        // R10: start beats jump
        start_i = 1'b1; start_addr_i = 22'h004010;
        jump_i = 1'b1;  jump_addr_i = 22'h000040;
        step();
        start_i = 1'b0; jump_i = 1'b0;
        collect(2, 20'h01004, 1'b1, "R10", fi, rb, lt, mr, gp);

        // R8: restart on the line held before the stop refills
        stop_i = 1'b1;
        step();
        stop_i = 1'b0;
        quiet(3, "R8");
        do_op(1'b0, 22'h004010);
        collect(2, 20'h01004, 1'b1, "R8", fi, rb, lt, mr, gp);
        chk(rb >= 1, "R8", "refill after restart", rb, 1);

        // R4: unaligned start byte address
        do_op(1'b0, 22'h00400B);
        collect(1, 20'h01002, 1'b1, "R4", fi, rb, lt, mr, gp);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule